// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This block decides the result of a two-input floating-point operation when at least one input is a NaN. It classifies each operand as a signaling NaN, a quiet NaN or any other value. A static policy code then chooses which operand is returned. A selected signaling NaN is quieted before it leaves the block. The block raises the invalid flags whenever a signaling operand is present. When asked, it returns a default NaN that is built from an 8-bit pattern.

NaN encoding follows the 2008 convention. A NaN has an all-ones exponent and a nonzero fraction. It is quiet when the fraction MSB is 1, and quieting sets that bit. The word width is a parameter: 32 gives binary32 and 64 gives binary64. A second parameter selects whether the outputs are registered with one cycle of latency, which is the default, or purely combinational. The bench uses FP_W = 32 and the registered form.

Top module: `nan_pick_top`

## Requirements
- R1: flag_invalid and flag_invalid_snan are both 1 exactly when op_a or op_b is a signaling NaN, meaning an all-ones exponent, a nonzero fraction and a fraction MSB of 0. This holds in every mode and for every policy code.
- R2: While dnan_mode is 1, res is the default NaN whatever the policy code.
- R3: The default NaN takes its sign from dnan_pat[7] and has an all-ones exponent. Its top seven fraction bits are dnan_pat[6:0], with dnan_pat[6] at the fraction MSB, and every lower fraction bit is a copy of dnan_pat[0]. A zero pattern is not a legal setting.
- R4: Code 0 returns op_a if op_a is any NaN and op_b otherwise. Code 1 returns op_b if op_b is any NaN and op_a otherwise.
- R5: Code 2 applies when some operand is signaling: it returns op_a if op_a is signaling and op_b otherwise. With no signaling operand, code 2 behaves as code 0. Code 3 is the mirror: it returns op_b if op_b is signaling and op_a otherwise, and falls back to code 1.
- R6: Under code 4, a signaling NaN paired with a quiet NaN yields the quiet one. A NaN paired with a non-NaN yields the NaN. Two non-NaNs yield op_b.
- R7: Under code 4, when both operands are NaNs of the same kind, the operand with the larger fraction field is returned. On equal fractions, op_a is returned only if op_a is positive and op_b is negative; otherwise op_b is returned.
- R8: When the chosen operand is a signaling NaN, res equals it with the fraction MSB set and every other bit unchanged.
- R9: Codes 5, 6 and 7 drive rule_err to 1 and return the default NaN. Codes 0 to 4 keep rule_err at 0.
- R10: With the output register enabled, outputs follow the inputs one clock later. During a synchronous active-low reset, res, both flags and rule_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | FP_W | First operand |
| op_b | input | FP_W | Second operand |
| rule_sel | input | 3 | Propagation policy code |
| dnan_mode | input | 1 | Force the default NaN as result |
| dnan_pat | input | 8 | Default NaN pattern |
| res | output | FP_W | Selected result word |
| flag_invalid | output | 1 | Invalid operation flag |
| flag_invalid_snan | output | 1 | Invalid caused by a signaling operand |
| rule_err | output | 1 | Unused policy code seen |

## Verification
The assertions check on every cycle the properties that do not depend on the chosen policy. These are the pairing of the two flags with the signaling inputs, the default NaN under dnan_mode and under unused codes, the error output, the absence of a signaling result outside default mode, the code 0 choice, and the cleared outputs under reset. Only the bench scenarios can show the finer policy behaviour. They sweep every class pairing under all eight codes in both modes, and they drive magnitude ties that differ only in sign or only in fraction, including pairs of signaling operands. They also apply default patterns whose low bit spreads into the whole lower fraction.

// File: rtl/nan_sel_pkg.sv
// Shared definitions for the NaN selector: operand classes and policy codes.
// Assumes the 2008 quiet-bit convention (fraction MSB set means quiet).
package nan_sel_pkg;
    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_QNAN  = 2'd1,
        CLS_SNAN  = 2'd2
    } nan_cls_e;

    localparam logic [2:0] RULE_A_FIRST  = 3'd0;
    localparam logic [2:0] RULE_B_FIRST  = 3'd1;
    localparam logic [2:0] RULE_SN_A     = 3'd2;
    localparam logic [2:0] RULE_SN_B     = 3'd3;
    localparam logic [2:0] RULE_MAG      = 3'd4;
endpackage

// File: rtl/nan_class_decode.sv
// Splits one operand into sign and fraction and classes it as signaling
// NaN, quiet NaN or other. Assumes the exponent sits just below the sign.
module nan_class_decode
    import nan_sel_pkg::*;
#(
    parameter int FP_W   = 32,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [FP_W-1:0]   word,
    output nan_cls_e          cls,
    output logic              sign,
    output logic [FRAC_W-1:0] frac
);
    logic [EXP_W-1:0] expo;

    // field split
    assign sign = word[FP_W-1];
    assign expo = word[FP_W-2 -: EXP_W];
    assign frac = word[FRAC_W-1:0];

    // class decision from exponent and quiet bit
    always_comb begin
        if ((&expo) && (|frac))
            cls = frac[FRAC_W-1] ? CLS_QNAN : CLS_SNAN;
        else
            cls = CLS_OTHER;
    end
endmodule

// File: rtl/dnan_build.sv
// Builds the default NaN word from the 8-bit pattern: sign from bit 7,
// bits 6:0 on the top fraction bits, bit 0 spread below. Assumes FRAC_W > 7.
module dnan_build #(
    parameter int FP_W   = 32,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [7:0]      pat,
    output logic [FP_W-1:0] word
);
    localparam int LOW_W = FRAC_W - 7;

    // assemble the word
    assign word = {pat[7], {EXP_W{1'b1}}, pat[6:0], {LOW_W{pat[0]}}};
endmodule

// File: rtl/nan_rule_pick.sv
// Applies the propagation policy to the two operand classes and reports
// whether operand b is taken. Unused codes raise rule_bad.
module nan_rule_pick
    import nan_sel_pkg::*;
#(
    parameter int FRAC_W = 23
) (
    input  logic [2:0]        rule,
    input  nan_cls_e          cls_a,
    input  nan_cls_e          cls_b,
    input  logic              sign_a,
    input  logic              sign_b,
    input  logic [FRAC_W-1:0] frac_a,
    input  logic [FRAC_W-1:0] frac_b,
    output logic              take_b,
    output logic              rule_bad
);
    logic a_nan, b_nan, a_sn, b_sn, a_q, b_q, any_sn, a_wins;

    // class helpers
    assign a_sn   = (cls_a == CLS_SNAN);
    assign b_sn   = (cls_b == CLS_SNAN);
    assign a_q    = (cls_a == CLS_QNAN);
    assign b_q    = (cls_b == CLS_QNAN);
    assign a_nan  = a_sn | a_q;
    assign b_nan  = b_sn | b_q;
    assign any_sn = a_sn | b_sn;

    // magnitude comparison with the positive-sign tie break
    assign a_wins = (frac_a > frac_b) ||
                    ((frac_a == frac_b) && !sign_a && sign_b);

    // policy decode
    always_comb begin
        take_b   = 1'b0;
        rule_bad = 1'b0;
        case (rule)
            RULE_A_FIRST: take_b = !a_nan;
            RULE_B_FIRST: take_b = b_nan;
            RULE_SN_A:    take_b = any_sn ? !a_sn : !a_nan;
            RULE_SN_B:    take_b = any_sn ? b_sn : b_nan;
            RULE_MAG: begin
                if (a_sn)
                    take_b = b_sn ? !a_wins : b_q;
                else if (a_q)
                    take_b = b_q ? !a_wins : 1'b0;
                else
                    take_b = 1'b1;
            end
            default:      rule_bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/nan_pick_top.sv
// Two-operand NaN selector. Classes both operands, applies the policy,
// quiets a signaling choice, substitutes the default NaN when forced or
// when the code is unused, and raises the invalid flags. REG_OUT = 1 adds
// one output register with synchronous active-low reset.
module nan_pick_top
    import nan_sel_pkg::*;
#(
    parameter int FP_W    = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    input  logic [2:0]      rule_sel,
    input  logic            dnan_mode,
    input  logic [7:0]      dnan_pat,
    output logic [FP_W-1:0] res,
    output logic            flag_invalid,
    output logic            flag_invalid_snan,
    output logic            rule_err
);
    localparam int EXP_W  = (FP_W == 64) ? 11 : 8;
    localparam int FRAC_W = FP_W - 1 - EXP_W;

    logic [FP_W-1:0]   opnd [2];
    nan_cls_e          cls  [2];
    logic              sgn  [2];
    logic [FRAC_W-1:0] frc  [2];
    logic              take_b, rule_bad, any_sn, chosen_sn;
    logic [FP_W-1:0]   dnan_word, chosen, quieted, nxt_res;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    // one class decoder per operand
    for (genvar k = 0; k < 2; k++) begin : g_dec
        nan_class_decode #(
            .FP_W   (FP_W),
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_dec (
            .word (opnd[k]),
            .cls  (cls[k]),
            .sign (sgn[k]),
            .frac (frc[k])
        );
    end

    nan_rule_pick #(
        .FRAC_W (FRAC_W)
    ) u_pick (
        .rule     (rule_sel),
        .cls_a    (cls[0]),
        .cls_b    (cls[1]),
        .sign_a   (sgn[0]),
        .sign_b   (sgn[1]),
        .frac_a   (frc[0]),
        .frac_b   (frc[1]),
        .take_b   (take_b),
        .rule_bad (rule_bad)
    );

    dnan_build #(
        .FP_W   (FP_W),
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_dnan (
        .pat  (dnan_pat),
        .word (dnan_word)
    );

    // signaling presence for the flags
    assign any_sn = (cls[0] == CLS_SNAN) || (cls[1] == CLS_SNAN);

    // operand choice, quieting and default substitution
    always_comb begin
        chosen    = take_b ? op_b : op_a;
        chosen_sn = take_b ? (cls[1] == CLS_SNAN) : (cls[0] == CLS_SNAN);
        quieted   = chosen;
        if (chosen_sn)
            quieted[FRAC_W-1] = 1'b1;
        nxt_res = (dnan_mode || rule_bad) ? dnan_word : quieted;
    end

    if (REG_OUT) begin : g_reg
        // output register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res               <= '0;
                flag_invalid      <= 1'b0;
                flag_invalid_snan <= 1'b0;
                rule_err          <= 1'b0;
            end else begin
                res               <= nxt_res;
                flag_invalid      <= any_sn;
                flag_invalid_snan <= any_sn;
                rule_err          <= rule_bad;
            end
        end
    end else begin : g_comb
        assign res               = nxt_res;
        assign flag_invalid      = any_sn;
        assign flag_invalid_snan = any_sn;
        assign rule_err          = rule_bad;
    end
endmodule

// File: rtl/nan_pick_chk.sv
// Property checker for nan_pick_top. Holds the inputs for the output
// latency and compares them with the outputs. Attached through bind.
module nan_pick_chk #(
    parameter int FP_W    = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [FP_W-1:0] op_a,
    input logic [FP_W-1:0] op_b,
    input logic [2:0]      rule_sel,
    input logic            dnan_mode,
    input logic [7:0]      dnan_pat,
    input logic [FP_W-1:0] res,
    input logic            flag_invalid,
    input logic            flag_invalid_snan,
    input logic            rule_err
);
    localparam int EXP_W  = (FP_W == 64) ? 11 : 8;
    localparam int FRAC_W = FP_W - 1 - EXP_W;

    logic [FP_W-1:0] h_a, h_b;
    logic [2:0]      h_rule;
    logic            h_mode, h_v;
    logic [7:0]      h_pat;

    function automatic logic is_nan(input logic [FP_W-1:0] w);
        return (&w[FP_W-2 -: EXP_W]) && (|w[FRAC_W-1:0]);
    endfunction

    function automatic logic is_sn(input logic [FP_W-1:0] w);
        return is_nan(w) && !w[FRAC_W-1];
    endfunction

    function automatic logic [FP_W-1:0] dflt(input logic [7:0] p);
        logic [FP_W-1:0] w;
        w = '1;
        w[FP_W-1] = p[7];
        for (int i = 0; i < FRAC_W; i++)
            w[i] = (i >= FRAC_W - 7) ? p[i - (FRAC_W - 7)] : p[0];
        return w;
    endfunction

    if (REG_OUT) begin : g_hold
        // input history for one cycle of latency
        always_ff @(posedge clk) begin
            h_v    <= rst_n;
            h_a    <= op_a;
            h_b    <= op_b;
            h_rule <= rule_sel;
            h_mode <= dnan_mode;
            h_pat  <= dnan_pat;
        end

        // R10
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (res == '0) && !flag_invalid && !flag_invalid_snan && !rule_err);
    end else begin : g_direct
        assign h_v    = 1'b1;
        assign h_a    = op_a;
        assign h_b    = op_b;
        assign h_rule = rule_sel;
        assign h_mode = dnan_mode;
        assign h_pat  = dnan_pat;
    end

    // R1
    flag_snan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_v |-> flag_invalid_snan == (is_sn(h_a) || is_sn(h_b)));

    // R1
    flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_v |-> flag_invalid == flag_invalid_snan);

    // R2
    dnan_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_v && h_mode) |-> res == dflt(h_pat));

    // R9
    rule_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_v |-> rule_err == (h_rule > 3'd4));

    // R9
    bad_rule_dnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_v && h_rule > 3'd4) |-> res == dflt(h_pat));

    // R8
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_v && !h_mode && h_rule <= 3'd4) |-> !is_sn(res));

    // R4
    a_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_v && !h_mode && h_rule == 3'd0 && is_nan(h_a))
        |-> res == (h_a | (FP_W'(1) << (FRAC_W - 1))));
endmodule

bind nan_pick_top nan_pick_chk #(
    .FP_W    (FP_W),
    .REG_OUT (REG_OUT)
) i_nan_pick_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .op_a              (op_a),
    .op_b              (op_b),
    .rule_sel          (rule_sel),
    .dnan_mode         (dnan_mode),
    .dnan_pat          (dnan_pat),
    .res               (res),
    .flag_invalid      (flag_invalid),
    .flag_invalid_snan (flag_invalid_snan),
    .rule_err          (rule_err)
);

// File: tb/test_nan_pick_top.sv
// Bench for nan_pick_top (binary32, registered). A behavioural model
// queues the expected outputs for each driven cycle and every clock
// compares the head of the queue with the design's outputs.
module test_nan_pick_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [2:0]  rule_sel = '0;
    logic        dnan_mode = 1'b0;
    logic [7:0]  dnan_pat = 8'h40;
    logic [31:0] res;
    logic        flag_invalid, flag_invalid_snan, rule_err;

    int checks = 0;
    int errors = 0;

    logic [31:0] q_res [$];
    logic        q_inv [$];
    logic        q_err [$];
    string       q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nan_pick_top #(.FP_W(32), .REG_OUT(1'b1)) i_nan_pick_top (
        .clk (clk), .rst_n (rst_n), .op_a (op_a), .op_b (op_b),
        .rule_sel (rule_sel), .dnan_mode (dnan_mode), .dnan_pat (dnan_pat),
        .res (res), .flag_invalid (flag_invalid),
        .flag_invalid_snan (flag_invalid_snan), .rule_err (rule_err)
    );

    function automatic bit nanq(input logic [31:0] w);
        return w[30:23] == 8'hFF && w[22:0] != 0;
    endfunction

    function automatic bit sigq(input logic [31:0] w);
        return nanq(w) && w[22] == 1'b0;
    endfunction

    function automatic logic [31:0] dnan_of(input logic [7:0] p);
        logic [31:0] w;
        w = {p[7], 8'hFF, p[6:0], 16'h0000};
        if (p[0]) w[15:0] = 16'hFFFF;
        return w;
    endfunction

    // behavioural expectation; also names the requirement that governs it
    task automatic model(input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] r, input bit m, input logic [7:0] p,
                         output logic [31:0] o, output logic e, output string tg);
        logic [31:0] pick;
        e  = (r > 4);
        tg = "R4";
        pick = a;
        if (r == 0) pick = nanq(a) ? a : b;
        else if (r == 1) pick = nanq(b) ? b : a;
        else if (r == 2) begin
            tg = "R5";
            if (sigq(a) || sigq(b)) pick = sigq(a) ? a : b;
            else pick = nanq(a) ? a : b;
        end else if (r == 3) begin
            tg = "R5";
            if (sigq(a) || sigq(b)) pick = sigq(b) ? b : a;
            else pick = nanq(b) ? b : a;
        end else if (r == 4) begin
            tg = "R6";
            if (!nanq(a)) pick = b;
            else if (!nanq(b)) pick = a;
            else if (sigq(a) != sigq(b)) pick = sigq(a) ? b : a;
            else begin
                tg = "R7";
                if (a[22:0] > b[22:0]) pick = a;
                else if (a[22:0] < b[22:0]) pick = b;
                else pick = (a[31] == 1'b0 && b[31] == 1'b1) ? a : b;
            end
        end
        if (sigq(pick) && r <= 4) begin
            pick[22] = 1'b1;
            if (tg == "R4") tg = "R8";
        end
        if (m) begin
            o = dnan_of(p);
            tg = "R2";
        end else if (e) begin
            o = dnan_of(p);
            tg = "R9";
        end else
            o = pick;
    endtask

    task automatic check(input bit ok, input string tg, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tg, what, act, exp);
        end
    endtask

    // compare outputs with the oldest queued expectation
    task automatic compare_head();
        logic [31:0] er;
        logic        ei, ee;
        string       tg;
        if (q_res.size() == 0) return;
        er = q_res.pop_front();
        ei = q_inv.pop_front();
        ee = q_err.pop_front();
        tg = q_tag.pop_front();
        check(res === er, tg, "res", res, er);
        check(flag_invalid === ei && flag_invalid_snan === ei,
              (tg == "R10") ? "R10" : "R1", "flags",
              {30'd0, flag_invalid, flag_invalid_snan}, {30'd0, ei, ei});
        check(rule_err === ee, (tg == "R10") ? "R10" : "R9", "rule_err",
              {31'd0, rule_err}, {31'd0, ee});
    endtask

    // one cycle: check the previous result, drive new inputs, queue expectation
    task automatic step(input bit rst, input logic [31:0] a, input logic [31:0] b,
                        input logic [2:0] r, input bit m, input logic [7:0] p,
                        input string tg_force);
        logic [31:0] o;
        logic        e;
        string       tg;
        @(negedge clk);
        compare_head();
        rst_n = rst; op_a = a; op_b = b; rule_sel = r; dnan_mode = m; dnan_pat = p;
        if (!rst) begin
            q_res.push_back('0); q_inv.push_back(1'b0);
            q_err.push_back(1'b0); q_tag.push_back("R10");
        end else begin
            model(a, b, r, m, p, o, e, tg);
            if (tg_force != "") tg = tg_force;
            q_res.push_back(o); q_inv.push_back(sigq(a) || sigq(b));
            q_err.push_back(e); q_tag.push_back(tg);
        end
    endtask

    logic [31:0] vals [6] = '{32'h3F80_0000, 32'h7F80_0000, 32'hFFC0_1234,
                              32'h7FC0_0042, 32'h7F80_0077, 32'hFFA0_0000};

    initial begin
        // R10: reset cycles with live NaN inputs
        for (int i = 0; i < 3; i++) step(1'b0, 32'h7F80_0001, 32'h7FC0_0000, 3'd0, 1'b0, 8'h40, "");
        // R1 R2 R4 R5 R6 R8 R9: every class pairing under every code, both modes
        for (int m = 0; m < 2; m++)
            for (int r = 0; r < 8; r++)
                for (int i = 0; i < 6; i++)
                    for (int j = 0; j < 6; j++)
                        step(1'b1, vals[i], vals[j], 3'(r), 1'(m), 8'h41, "");
        // R7: magnitude ties and fraction order, quiet and signaling pairs
        step(1'b1, 32'hFFC0_0010, 32'h7FC0_0010, 3'd4, 1'b0, 8'h40, "R7");
        step(1'b1, 32'h7FC0_0010, 32'hFFC0_0010, 3'd4, 1'b0, 8'h40, "R7");
        step(1'b1, 32'h7FC0_0010, 32'h7FC0_0010, 3'd4, 1'b0, 8'h40, "R7");
        step(1'b1, 32'hFFC0_0010, 32'hFFC0_0010, 3'd4, 1'b0, 8'h40, "R7");
        step(1'b1, 32'h7FC0_0300, 32'hFFC0_0020, 3'd4, 1'b0, 8'h40, "R7");
        step(1'b1, 32'h7F80_0010, 32'h7F80_0020, 3'd4, 1'b0, 8'h40, "R7");
        step(1'b1, 32'hFF80_0020, 32'h7F80_0020, 3'd4, 1'b0, 8'h40, "R7");
        step(1'b1, 32'h7F80_0020, 32'hFF80_0020, 3'd4, 1'b0, 8'h40, "R7");
        // R3: default patterns with and without low-bit fill
        step(1'b1, 32'h7FC0_0001, 32'h0, 3'd0, 1'b1, 8'hC0, "R3");
        step(1'b1, 32'h7FC0_0001, 32'h0, 3'd1, 1'b1, 8'h7F, "R3");
        step(1'b1, 32'h7F80_0001, 32'h0, 3'd4, 1'b1, 8'h41, "R3");
        step(1'b1, 32'h0, 32'h7FC0_0001, 3'd6, 1'b0, 8'hE5, "R3");
        step(1'b1, 32'h0, 32'h7FC0_0001, 3'd5, 1'b0, 8'h01, "R3");
        // R10: reset again mid-run, then drain
        step(1'b0, 32'h7F80_0001, 32'h7F80_0002, 3'd7, 1'b1, 8'hFF, "");
        step(1'b1, 32'h7F80_0001, 32'h3F80_0000, 3'd2, 1'b0, 8'h40, "");
        @(negedge clk);
        compare_head();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule